// File: doc/BRIEF.md
# UART Interrupt Identification and Request Unit

This block decides which interrupt source a 16550-style serial controller reports, and drives the interrupt request line. It sees the enable mask, live receive status (data ready, parity and framing errors on the head byte, receive FIFO fill count), the FIFO enable and trigger selection, a character-timeout flag and the transmit-holding-empty status. It also takes one-cycle event pulses for overrun, break and the four modem-line changes. The register decoder supplies strobes for enable writes and for reads of the identification, line status and modem status registers.

The unit holds the enable mask, a sticky overrun flag, a sticky break flag, four sticky modem change flags and the transmit-empty pending flag. Each cycle it picks the highest-priority active source among five fixed levels. It registers the result into an 8-bit identification value and the request line. The surrounding register file returns `iir_q` on identification reads and builds its status reads from the sticky flag outputs.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, `iir_q` is 0x01, `irq` is 0, `ier_q` is 0, and all sticky flags (`ovr_q`, `brk_q`, `mdm_delta_q`) are 0.
- R2: An enable write stores only bits 3:0 of `ier_wdata` into `ier_q`. The bit meanings are: 0 received data, 1 transmit empty, 2 line status, 3 modem. The stored value is visible one clock after the strobe.
- R3: `iir_q[3:0]` shows the highest active source, from highest to lowest: line status 0x6, character timeout 0xC, received data 0x4, transmit empty 0x2, modem 0x0. When no source is active it shows 0x1. Only bit 0 = 1 means nothing is pending.
- R4: The line status source is active when enable bit 2 is set and any of overrun, break, `rx_pe` or `rx_fe` is set.
- R5: The character timeout source is active only when `char_tmo` is set and enable bit 0 is set.
- R6: The received data source needs enable bit 0 and `rx_ready`. With `fifo_en` low, nothing else is required. With `fifo_en` high, `rx_count` must also be at least the trigger level. `trig_sel` values 0,1,2,3 select levels 1, DEPTH/4, DEPTH/2 and DEPTH-2, which are 1, 4, 8 and 14 at the default depth of 16.
- R7: `iir_q[7:6]` is 11 when `fifo_en` is high and 00 when it is low. `iir_q[5:4]` is always 00.
- R8: An identification read while `iir_q[3:0]` is 0x2 clears the transmit-empty pending flag. A read showing any other value leaves the flag unchanged.
- R9: When an enable write changes bit 1, the pending flag becomes (new bit 1 AND `lsr_thre`). An enable write that leaves bit 1 unchanged does not touch the flag.
- R10: A transmit FIFO reset pulse sets the pending flag. Same-cycle events rank as follows: FIFO reset first, then an enable write that changes bit 1, then an identification read.
- R11: An `ovr_set` or `brk_set` pulse sets its sticky flag. A line status read clears both flags. When a set pulse and a read fall in the same cycle, the set wins.
- R12: Each `mdm_delta_set` bit sets its sticky change flag. A modem status read clears all four flags. When a set and a read fall in the same cycle, the set wins.
- R13: `irq` is high exactly when the registered identification shows a pending source. `irq` and `iir_q` change on the same edge, one clock after the inputs and state they reflect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Write data for the enable register |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status read strobe |
| msr_rd | input | 1 | Modem status read strobe |
| txf_rst | input | 1 | Transmit FIFO reset pulse |
| fifo_en | input | 1 | FIFO mode enabled |
| trig_sel | input | 2 | Receive trigger level select |
| rx_count | input | CW | Receive FIFO fill count |
| rx_ready | input | 1 | Receive data ready |
| rx_pe | input | 1 | Parity error on head byte |
| rx_fe | input | 1 | Framing error on head byte |
| ovr_set | input | 1 | Overrun event pulse |
| brk_set | input | 1 | Break event pulse |
| lsr_thre | input | 1 | Transmit holding register empty status |
| char_tmo | input | 1 | Character timeout pending |
| mdm_delta_set | input | 4 | Modem line change event pulses |
| ier_q | output | 4 | Stored enable mask |
| ovr_q | output | 1 | Sticky overrun flag |
| brk_q | output | 1 | Sticky break flag |
| mdm_delta_q | output | 4 | Sticky modem change flags |
| iir_q | output | 8 | Registered identification value |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the FIFO trigger boundary (count one below and exactly at the level). A wrong comparison there would raise the data interrupt one byte early or late. It checks the timeout while the data enable is off, where a design that forgets the mask would show 0xC with no way to silence it. It drives same-cycle collisions: a set pulse against a clearing read, and a FIFO reset against an identification read. A wrong winner there would lose an overrun or a transmit-empty event. It also rewrites the enable register without changing bit 1 and checks that the pending flag is left alone, because an over-eager resample would resurrect an interrupt that was already acknowledged.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

   // identification codes, highest priority first
   localparam logic [3:0] ID_LINE  = 4'h6;
   localparam logic [3:0] ID_TMO   = 4'hC;
   localparam logic [3:0] ID_DATA  = 4'h4;
   localparam logic [3:0] ID_THRE  = 4'h2;
   localparam logic [3:0] ID_MODEM = 4'h0;
   localparam logic [3:0] ID_NONE  = 4'h1;

   // enable mask bit positions
   localparam int EN_DATA  = 0;
   localparam int EN_THRE  = 1;
   localparam int EN_LINE  = 2;
   localparam int EN_MODEM = 3;

   localparam int ENABLE_W = 4;
   localparam int DELTA_W  = 4;

   function automatic int unsigned trig_level(input logic [1:0] sel,
                                              input int unsigned depth);
      case (sel)
         2'd0:    return 1;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky #(
   parameter int WIDTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             clr_i,
   output logic [WIDTH-1:0] flag_q
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("uart_irq_sticky: WIDTH must be at least 1");
      end
   endgenerate

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          flag_q[b] <= 1'b0;
         else if (set_i[b])   flag_q[b] <= 1'b1;
         else if (clr_i)      flag_q[b] <= 1'b0;
      end

      // shared by the line status (R11) and modem change (R12) instances
      assert_sticky_set_R11 : assert property (@(posedge clk) disable iff (!rst_n)
         set_i[b] |=> flag_q[b]);
      assert_sticky_clear_R12 : assert property (@(posedge clk) disable iff (!rst_n)
         (clr_i && !set_i[b]) |=> !flag_q[b]);
      assert_sticky_hold_R11 : assert property (@(posedge clk) disable iff (!rst_n)
         (!clr_i && !set_i[b]) |=> $stable(flag_q[b]));
   end

endmodule

// File: rtl/uart_irq_thre.sv
module uart_irq_thre
   import uart_irq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ier_wr,
   input  logic [ENABLE_W-1:0] ier_wdata,
   input  logic                iir_rd,
   input  logic [3:0]          iir_id,
   input  logic                txf_rst,
   input  logic                lsr_thre,
   output logic [ENABLE_W-1:0] ier_q,
   output logic                thre_pend
);

   logic thre_bit_chg;
   logic thre_next;

   assign thre_bit_chg = ier_wr && (ier_wdata[EN_THRE] != ier_q[EN_THRE]);

   always_comb begin
      thre_next = thre_pend;
      if (txf_rst)
         thre_next = 1'b1;
      else if (thre_bit_chg)
         thre_next = ier_wdata[EN_THRE] && lsr_thre;
      else if (iir_rd && (iir_id == ID_THRE))
         thre_next = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ier_q     <= '0;
         thre_pend <= 1'b0;
      end else begin
         if (ier_wr) ier_q <= ier_wdata;
         thre_pend <= thre_next;
      end
   end

   assert_ier_store_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      ier_wr |=> (ier_q == $past(ier_wdata)));
   assert_ack_clear_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (iir_rd && iir_id == ID_THRE && !txf_rst && !thre_bit_chg) |=> !thre_pend);
   assert_resample_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (thre_bit_chg && !txf_rst) |=> (thre_pend == ($past(ier_wdata[EN_THRE]) && $past(lsr_thre))));
   assert_fifo_reset_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      txf_rst |=> thre_pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
   import uart_irq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic [ENABLE_W-1:0] ier,
   input  logic                line_any,
   input  logic                char_tmo,
   input  logic                rx_ready,
   input  logic                fifo_en,
   input  logic [1:0]          trig_sel,
   input  logic [CW-1:0]       rx_count,
   input  logic                thre_pend,
   input  logic                mdm_any,
   output logic [3:0]          id
);

   logic [CW-1:0] level;
   logic          reached;
   logic          src_line, src_tmo, src_data, src_thre, src_modem;

   always_comb begin
      level = CW'(trig_level(trig_sel, DEPTH));
   end

   assign reached   = (rx_count >= level);
   assign src_line  = ier[EN_LINE]  && line_any;
   assign src_tmo   = ier[EN_DATA]  && char_tmo;
   assign src_data  = ier[EN_DATA]  && rx_ready && (!fifo_en || reached);
   assign src_thre  = ier[EN_THRE]  && thre_pend;
   assign src_modem = ier[EN_MODEM] && mdm_any;

   always_comb begin
      if      (src_line)  id = ID_LINE;
      else if (src_tmo)   id = ID_TMO;
      else if (src_data)  id = ID_DATA;
      else if (src_thre)  id = ID_THRE;
      else if (src_modem) id = ID_MODEM;
      else                id = ID_NONE;
   end

endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
   import uart_irq_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CW    = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ier_wr,
   input  logic [7:0]    ier_wdata,
   input  logic          iir_rd,
   input  logic          lsr_rd,
   input  logic          msr_rd,
   input  logic          txf_rst,
   input  logic          fifo_en,
   input  logic [1:0]    trig_sel,
   input  logic [CW-1:0] rx_count,
   input  logic          rx_ready,
   input  logic          rx_pe,
   input  logic          rx_fe,
   input  logic          ovr_set,
   input  logic          brk_set,
   input  logic          lsr_thre,
   input  logic          char_tmo,
   input  logic [3:0]    mdm_delta_set,
   output logic [3:0]    ier_q,
   output logic          ovr_q,
   output logic          brk_q,
   output logic [3:0]    mdm_delta_q,
   output logic [7:0]    iir_q,
   output logic          irq
);

   localparam int LINE_W = 2;

   generate
      if (DEPTH < 8 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("uart_irq_ident: DEPTH must be a power of two, at least 8");
      end
      if (CW < $clog2(DEPTH + 1)) begin : g_bad_cw
         $error("uart_irq_ident: CW too narrow for DEPTH");
      end
   endgenerate

   logic [LINE_W-1:0] line_flags;
   logic              thre_pend;
   logic [3:0]        id_next;
   logic [7:0]        iir_next;

   uart_irq_thre u_thre (
      .clk       (clk),
      .rst_n     (rst_n),
      .ier_wr    (ier_wr),
      .ier_wdata (ier_wdata[ENABLE_W-1:0]),
      .iir_rd    (iir_rd),
      .iir_id    (iir_q[3:0]),
      .txf_rst   (txf_rst),
      .lsr_thre  (lsr_thre),
      .ier_q     (ier_q),
      .thre_pend (thre_pend)
   );

   uart_irq_sticky #(.WIDTH(LINE_W)) u_line (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  ({brk_set, ovr_set}),
      .clr_i  (lsr_rd),
      .flag_q (line_flags)
   );

   uart_irq_sticky #(.WIDTH(DELTA_W)) u_modem (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (mdm_delta_set),
      .clr_i  (msr_rd),
      .flag_q (mdm_delta_q)
   );

   assign ovr_q = line_flags[0];
   assign brk_q = line_flags[1];

   uart_irq_prio #(.DEPTH(DEPTH), .CW(CW)) u_prio (
      .ier       (ier_q),
      .line_any  (ovr_q || brk_q || rx_pe || rx_fe),
      .char_tmo  (char_tmo),
      .rx_ready  (rx_ready),
      .fifo_en   (fifo_en),
      .trig_sel  (trig_sel),
      .rx_count  (rx_count),
      .thre_pend (thre_pend),
      .mdm_any   (|mdm_delta_q),
      .id        (id_next)
   );

   assign iir_next = {{2{fifo_en}}, 2'b00, id_next};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iir_q <= {4'h0, ID_NONE};
         irq   <= 1'b0;
      end else begin
         iir_q <= iir_next;
         irq   <= (id_next != ID_NONE);
      end
   end

   assert_line_first_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q[EN_LINE] && (ovr_q || brk_q)) |=> (iir_q[3:0] == ID_LINE));
   assert_data_mask_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      !ier_q[EN_DATA] |=> (iir_q[3:0] != ID_TMO && iir_q[3:0] != ID_DATA));
   assert_mode_bits_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      !fifo_en |=> (iir_q[7:4] == 4'h0));
   assert_quiet_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      (ier_q == '0) |=> !irq);
   assert_req_id_R13 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !iir_q[0]);

endmodule

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;

   localparam int DEPTH = 16;
   localparam int CW    = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ier_wr = 0, iir_rd = 0, lsr_rd = 0, msr_rd = 0, txf_rst = 0;
   logic [7:0]    ier_wdata = 0;
   logic          fifo_en = 0, rx_ready = 0, rx_pe = 0, rx_fe = 0;
   logic [1:0]    trig_sel = 0;
   logic [CW-1:0] rx_count = 0;
   logic          ovr_set = 0, brk_set = 0, lsr_thre = 0, char_tmo = 0;
   logic [3:0]    mdm_delta_set = 0;
   logic [3:0]    ier_q;
   logic          ovr_q, brk_q, irq;
   logic [3:0]    mdm_delta_q;
   logic [7:0]    iir_q;

   int errors = 0;
   int checks = 0;
   string cur_tag = "R1";

   // reference state built from the requirements
   logic [3:0] m_ier = 0;
   logic       m_thre = 0, m_ovr = 0, m_brk = 0;
   logic [3:0] m_delta = 0;
   logic [7:0] m_iir = 8'h01;

   always #4 clk = ~clk;

   uart_irq_ident #(.DEPTH(DEPTH), .CW(CW)) u_uart_irq_ident (
      .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata),
      .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .txf_rst(txf_rst),
      .fifo_en(fifo_en), .trig_sel(trig_sel), .rx_count(rx_count),
      .rx_ready(rx_ready), .rx_pe(rx_pe), .rx_fe(rx_fe), .ovr_set(ovr_set),
      .brk_set(brk_set), .lsr_thre(lsr_thre), .char_tmo(char_tmo),
      .mdm_delta_set(mdm_delta_set), .ier_q(ier_q), .ovr_q(ovr_q),
      .brk_q(brk_q), .mdm_delta_q(mdm_delta_q), .iir_q(iir_q), .irq(irq)
   );

   function automatic int level_of(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 4;
         2'd2: return 8;
         default: return 14;
      endcase
   endfunction

   function automatic logic [3:0] ref_id();
      if (m_ier[2] && (m_ovr || m_brk || rx_pe || rx_fe)) return 4'h6;
      if (m_ier[0] && char_tmo) return 4'hC;
      if (m_ier[0] && rx_ready && (!fifo_en || int'(rx_count) >= level_of(trig_sel))) return 4'h4;
      if (m_ier[1] && m_thre) return 4'h2;
      if (m_ier[3] && (m_delta != 0)) return 4'h0;
      return 4'h1;
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // inputs are set at a falling edge; one rising edge later the outputs reflect them
   task automatic step();
      logic [3:0] e_id;
      logic [7:0] e_iir;
      logic [3:0] n_ier;
      logic       n_thre, n_ovr, n_brk;
      logic [3:0] n_delta;
      e_id  = ref_id();
      e_iir = {fifo_en ? 2'b11 : 2'b00, 2'b00, e_id};
      n_ier = ier_wr ? ier_wdata[3:0] : m_ier;
      if (txf_rst) n_thre = 1'b1;
      else if (ier_wr && (ier_wdata[1] != m_ier[1])) n_thre = ier_wdata[1] && lsr_thre;
      else if (iir_rd && m_iir[3:0] == 4'h2) n_thre = 1'b0;
      else n_thre = m_thre;
      n_ovr   = ovr_set || (m_ovr && !lsr_rd);
      n_brk   = brk_set || (m_brk && !lsr_rd);
      n_delta = mdm_delta_set | (m_delta & {4{!msr_rd}});
      @(posedge clk);
      m_ier = n_ier; m_thre = n_thre; m_ovr = n_ovr; m_brk = n_brk; m_delta = n_delta;
      m_iir = e_iir;
      @(negedge clk);
      check(cur_tag, int'(iir_q), int'(e_iir));
      check("R13", int'(irq), int'(e_id != 4'h1));
      check("R2", int'(ier_q), int'(m_ier));
      check("R11", int'({brk_q, ovr_q}), int'({m_brk, m_ovr}));
      check("R12", int'(mdm_delta_q), int'(m_delta));
      ier_wr = 0; iir_rd = 0; lsr_rd = 0; msr_rd = 0; txf_rst = 0;
      ovr_set = 0; brk_set = 0; mdm_delta_set = 0;
   endtask

   task automatic wr_ier(input logic [7:0] v);
      ier_wr = 1; ier_wdata = v; step();
   endtask

   initial begin
      #(200000 * 8);
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      void'($urandom(32'h1A2B3C4D));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", int'(iir_q), 8'h01);
      check("R1", int'(irq), 0);
      check("R1", int'(ier_q), 0);
      check("R1", int'({brk_q, ovr_q, mdm_delta_q}), 0);

      // R2 only low nibble kept
      cur_tag = "R2"; wr_ier(8'hF0); wr_ier(8'hAD); wr_ier(8'h00);

      // R5 timeout masked by data enable
      cur_tag = "R5"; char_tmo = 1; step(); wr_ier(8'h01); step();
      char_tmo = 0;

      // R6 trigger boundary and FIFO-off case
      cur_tag = "R6"; fifo_en = 1; trig_sel = 3; rx_ready = 1; rx_count = 13; step();
      rx_count = 14; step();
      trig_sel = 1; rx_count = 3; step(); rx_count = 4; step();
      trig_sel = 0; rx_count = 1; step();
      fifo_en = 0; rx_count = 0; step();

      // R7 mode bits
      cur_tag = "R7"; rx_ready = 0; fifo_en = 1; step(); fifo_en = 0; step();

      // R9 resample on bit 1 change, untouched when unchanged
      cur_tag = "R9"; lsr_thre = 1; wr_ier(8'h03); step();
      cur_tag = "R8"; iir_rd = 1; step(); step();
      cur_tag = "R9"; wr_ier(8'h03); step();
      wr_ier(8'h01); lsr_thre = 0; wr_ier(8'h03); step();

      // R10 FIFO reset beats a same-cycle acknowledge
      cur_tag = "R10"; txf_rst = 1; step(); iir_rd = 1; txf_rst = 1; step(); step();
      cur_tag = "R8"; iir_rd = 1; step(); step();

      // R3 full stack, peeled level by level
      cur_tag = "R3"; lsr_thre = 1; wr_ier(8'h0D); wr_ier(8'h0F);
      ovr_set = 1; mdm_delta_set = 4'h5; char_tmo = 1; rx_ready = 1; step(); step();
      lsr_rd = 1; step(); char_tmo = 0; step(); rx_ready = 0; step();
      iir_rd = 1; step(); msr_rd = 1; step(); step();

      // R4 live head-byte errors and break
      cur_tag = "R4"; rx_pe = 1; step(); rx_pe = 0; rx_fe = 1; step(); rx_fe = 0;
      brk_set = 1; step(); lsr_rd = 1; step();

      // R11 / R12 set wins over clearing read
      cur_tag = "R11"; ovr_set = 1; lsr_rd = 1; step(); lsr_rd = 1; step();
      cur_tag = "R12"; mdm_delta_set = 4'h8; msr_rd = 1; step(); msr_rd = 1; step();

      // constrained random mix
      cur_tag = "R3";
      for (int i = 0; i < 3000; i++) begin
         ier_wr        = ($urandom_range(0, 7) == 0);
         ier_wdata     = 8'($urandom());
         iir_rd        = ($urandom_range(0, 3) == 0);
         lsr_rd        = ($urandom_range(0, 5) == 0);
         msr_rd        = ($urandom_range(0, 5) == 0);
         txf_rst       = ($urandom_range(0, 15) == 0);
         fifo_en       = ($urandom_range(0, 1) == 1);
         trig_sel      = 2'($urandom());
         rx_count      = CW'($urandom_range(0, DEPTH));
         rx_ready      = ($urandom_range(0, 1) == 1);
         rx_pe         = ($urandom_range(0, 15) == 0);
         rx_fe         = ($urandom_range(0, 15) == 0);
         ovr_set       = ($urandom_range(0, 9) == 0);
         brk_set       = ($urandom_range(0, 9) == 0);
         lsr_thre      = ($urandom_range(0, 1) == 1);
         char_tmo      = ($urandom_range(0, 3) == 0);
         mdm_delta_set = 4'($urandom()) & 4'($urandom()) & 4'($urandom());
         step();
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule